// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of which of a small set of fixed-size packet buffer pages are in use by an Ethernet controller. It holds a usage bitmap and three page-number queues. The transmit queue holds pages that are waiting to be sent. The completion queue holds pages that have been sent but not yet released. The receive queue holds pages that the receive path has filled. Page data storage, the interrupt register and the host bus interface sit outside this block.

Three sources drive the allocator:
- A host command, which carries a 3-bit opcode and a packet-number operand.
- A receive-path allocation request, answered in the same cycle.
- A dequeue strobe from the frame transmit engine.

Only one of these events takes effect per clock. A host command has the highest priority, then a transmit dequeue, then a receive request.

The host reads back three things: the last transmit allocation result, the number of pages in use, and the heads of the receive and completion queues. A failed transmit allocation stays pending and is retried on the next page release. The interrupt logic outside receives set and clear pulses.

Top module: `pkt_page_alloc`

## Requirements
- R1: Every allocation takes the lowest-numbered free page. A transmit allocation that finds no free page leaves `alloc_result_o` at the failure code 0x80. After reset, `alloc_result_o` is 0.
- R2: The opcode `cmd_op_i` (bits 7:5 of the host command byte) is acted on only while `cmd_valid_i` is high. Opcode 0 is a no-op that changes no state.
- R3: Opcode 1 (allocate for transmit) behaves as follows:
  - It pulses `alloc_done_clr_o`.
  - If a page is free, `alloc_result_o` holds that page number from the next cycle and `alloc_done_set_o` pulses in the same cycle as the command.
  - If no page is free, `alloc_result_o` reads 0x80 from the next cycle.
- R4: Any page release while `alloc_result_o` is 0x80 retries the allocation in the same cycle. A success claims the lowest free page after the release and pulses `alloc_done_set_o`.
  - Opcode 5 releases the page named by `pkt_num_i`.
  - Opcode 4 releases the receive head.
  - A transmit dequeue with auto-release also releases a page.
- R5: `rx_head_o` and `done_head_o` read 0x80 when their queue is empty. Otherwise they read the head page number in the low bits, with the upper bits zero.
- R6: Opcode 3 pops the receive queue and opcode 4 releases the receive head and then pops it. For both:
  - `rx_int_set_o` pulses if more than one entry was present.
  - `rx_int_clr_o` pulses otherwise.
  - On an empty queue, nothing is popped or released.
- R7: On a transmit dequeue with `auto_release_i` high, the page is freed at once. With `auto_release_i` low, the page is appended to the completion queue, unless that queue already holds four entries.
- R8: Opcode 6 appends `pkt_num_i` to the transmit queue. The append is ignored when the queue already holds four entries.
- R9: `pages_used_o` equals the number of set bits in the usage bitmap.
- R10: `tx_valid_o` is high only while `tx_enable_i` is high, the transmit queue is not empty and no command is valid. Each `tx_deq_i` pulse while `tx_valid_o` is high removes exactly one entry, in FIFO order, and `tx_page_o` shows the head.
- R11: `rx_grant_o` answers `rx_alloc_req_i` in the same cycle, with the lowest free page on `rx_page_o`.
  - The grant is refused while a command is valid, while a dequeue fires, or while no page is free.
  - A grant marks the page used, appends it to the receive queue and pulses `rx_int_set_o`.
- R12: Opcode 2 empties all three queues, clears the bitmap and sets `alloc_result_o` to 0. Opcode 7 empties only the transmit and completion queues.
- R13: `done_pop_i` removes the completion queue head and has no effect on an empty queue. Opcodes 2 and 7 override it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 3 | Command opcode |
| pkt_num_i | input | PW | Packet-number register value |
| auto_release_i | input | 1 | Free transmitted pages immediately |
| tx_enable_i | input | 1 | Transmit path enabled |
| tx_deq_i | input | 1 | Transmit engine takes the head page |
| rx_alloc_req_i | input | 1 | Receive path requests a page |
| done_pop_i | input | 1 | Acknowledge the completion queue head |
| rx_grant_o | output | 1 | Receive request granted |
| rx_page_o | output | PW | Page granted to receive |
| tx_valid_o | output | 1 | Transmit head available |
| tx_page_o | output | PW | Transmit queue head |
| alloc_result_o | output | 8 | Transmit allocation result, 0x80 on failure |
| pages_used_o | output | CW | Pages in use |
| rx_head_o | output | 8 | Receive queue head, 0x80 when empty |
| done_head_o | output | 8 | Completion queue head, 0x80 when empty |
| alloc_done_set_o | output | 1 | Pulse: raise allocation-done interrupt |
| alloc_done_clr_o | output | 1 | Pulse: clear allocation-done interrupt |
| rx_int_set_o | output | 1 | Pulse: raise receive interrupt |
| rx_int_clr_o | output | 1 | Pulse: clear receive interrupt |

## Verification
The hardest case to reach is a failed transmit allocation that is later satisfied by a page freed through a transmit dequeue with auto-release. That path needs every page in use, a queued transmit, a failed opcode 1 and then an enabled dequeue, all in order. The bench reaches it in a directed phase:
- It fills every page through receive grants.
- It enqueues one of those pages for transmit and issues a failing allocate.
- It then raises transmit enable with auto-release and strobes a dequeue, expecting the retry to claim the freed page.

A long stretch of mixed random traffic then crosses the queue-full, empty-pop and simultaneous pop/append boundaries against the behavioural model.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_ALLOC_TX   = 3'd1,
    OP_RESET_ALL  = 3'd2,
    OP_RX_POP     = 3'd3,
    OP_RX_POP_REL = 3'd4,
    OP_RELEASE    = 3'd5,
    OP_TX_ENQ     = 3'd6,
    OP_TX_CLR     = 3'd7
  } mmu_op_e;

  localparam logic [7:0] ALLOC_FAIL = 8'h80;
endpackage

// File: rtl/page_fifo.sv
module page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != FULL_C);
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST_C) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST_C) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clear_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/page_pick.sv
module page_pick #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  used_i,
  output logic          found_o,
  output logic [PW-1:0] idx_o
);
  // descending scan: the lowest free page is assigned last and wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_i[i]) begin
        found_o = 1'b1;
        idx_o   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [PW-1:0] pkt_num_i,
  input  logic          auto_release_i,
  input  logic          tx_enable_i,
  input  logic          tx_deq_i,
  input  logic          rx_alloc_req_i,
  input  logic          done_pop_i,
  output logic          rx_grant_o,
  output logic [PW-1:0] rx_page_o,
  output logic          tx_valid_o,
  output logic [PW-1:0] tx_page_o,
  output logic [7:0]    alloc_result_o,
  output logic [CW-1:0] pages_used_o,
  output logic [7:0]    rx_head_o,
  output logic [7:0]    done_head_o,
  output logic          alloc_done_set_o,
  output logic          alloc_done_clr_o,
  output logic          rx_int_set_o,
  output logic          rx_int_clr_o
);
  localparam int QD = NUM_PAGES;
  localparam int QCW = $clog2(QD + 1);

  mmu_op_e op;
  assign op = cmd_valid_i ? mmu_op_e'(cmd_op_i) : OP_NOP;

  logic [NUM_PAGES-1:0] used_q, used_d, used_rel, rel_mask, set_mask;
  logic [7:0]           result_q, result_d;

  logic [PW-1:0]  rx_head, tx_head, done_head;
  logic [QCW-1:0] rx_cnt, tx_cnt, done_cnt;
  logic           rx_empty, tx_empty, done_empty;

  logic tx_fire, rx_pop, q_clear_all, q_clear_tx;
  logic rel_en;
  logic [PW-1:0] rel_page;
  logic pick_found;
  logic [PW-1:0] pick_idx;
  logic alloc_try, alloc_ok;

  assign q_clear_all = (op == OP_RESET_ALL);
  assign q_clear_tx  = q_clear_all || (op == OP_TX_CLR);
  assign rx_pop      = (op == OP_RX_POP) || (op == OP_RX_POP_REL);
  assign tx_valid_o  = tx_enable_i && !tx_empty && !cmd_valid_i;
  assign tx_fire     = tx_deq_i && tx_valid_o;
  assign tx_page_o   = tx_head;

  // at most one release source is active in a cycle
  always_comb begin
    rel_en   = 1'b0;
    rel_page = '0;
    if (op == OP_RX_POP_REL && !rx_empty) begin
      rel_en   = 1'b1;
      rel_page = rx_head;
    end else if (op == OP_RELEASE) begin
      rel_en   = 1'b1;
      rel_page = pkt_num_i;
    end else if (tx_fire && auto_release_i) begin
      rel_en   = 1'b1;
      rel_page = tx_head;
    end
  end

  assign rel_mask = rel_en ? (NUM_PAGES'(1) << rel_page) : '0;
  assign used_rel = used_q & ~rel_mask;

  page_pick #(.N(NUM_PAGES)) u_pick (
    .used_i  (used_rel),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  assign alloc_try  = (op == OP_ALLOC_TX) || (rel_en && result_q == ALLOC_FAIL);
  assign alloc_ok   = alloc_try && pick_found;
  assign rx_grant_o = rx_alloc_req_i && !cmd_valid_i && !tx_fire && pick_found;
  assign rx_page_o  = pick_idx;
  assign set_mask   = (alloc_ok || rx_grant_o) ? (NUM_PAGES'(1) << pick_idx) : '0;

  always_comb begin
    used_d   = used_rel | set_mask;
    result_d = result_q;
    if (alloc_ok)                result_d = 8'(pick_idx);
    else if (op == OP_ALLOC_TX)  result_d = ALLOC_FAIL;
    if (q_clear_all) begin
      used_d   = '0;
      result_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q   <= '0;
      result_q <= '0;
    end else begin
      used_q   <= used_d;
      result_q <= result_d;
    end
  end

  page_fifo #(.DEPTH(QD), .W(PW)) u_rx_q (
    .clk_i, .rst_ni,
    .clear_i (q_clear_all),
    .push_i  (rx_grant_o),
    .data_i  (pick_idx),
    .pop_i   (rx_pop),
    .head_o  (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_empty)
  );

  page_fifo #(.DEPTH(QD), .W(PW)) u_tx_q (
    .clk_i, .rst_ni,
    .clear_i (q_clear_tx),
    .push_i  (op == OP_TX_ENQ),
    .data_i  (pkt_num_i),
    .pop_i   (tx_fire),
    .head_o  (tx_head),
    .count_o (tx_cnt),
    .empty_o (tx_empty)
  );

  page_fifo #(.DEPTH(QD), .W(PW)) u_done_q (
    .clk_i, .rst_ni,
    .clear_i (q_clear_tx),
    .push_i  (tx_fire && !auto_release_i),
    .data_i  (tx_head),
    .pop_i   (done_pop_i),
    .head_o  (done_head),
    .count_o (done_cnt),
    .empty_o (done_empty)
  );

  always_comb begin
    pages_used_o = '0;
    for (int i = 0; i < NUM_PAGES; i++) pages_used_o += CW'(used_q[i]);
  end

  assign alloc_result_o   = result_q;
  assign rx_head_o        = rx_empty   ? ALLOC_FAIL : 8'(rx_head);
  assign done_head_o      = done_empty ? ALLOC_FAIL : 8'(done_head);
  assign alloc_done_set_o = alloc_ok;
  assign alloc_done_clr_o = (op == OP_ALLOC_TX);
  assign rx_int_set_o     = rx_grant_o || (rx_pop && rx_cnt > QCW'(1));
  assign rx_int_clr_o     = rx_pop && rx_cnt <= QCW'(1);

  // counts only feed the full/empty logic inside the queues
  logic unused_cnt;
  assign unused_cnt = ^{tx_cnt, done_cnt};
endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
  parameter int NUM_PAGES = 4,
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic          tx_enable_i,
  input logic          rx_grant_o,
  input logic          tx_valid_o,
  input logic [CW-1:0] pages_used_o,
  input logic [7:0]    rx_head_o,
  input logic [7:0]    done_head_o,
  input logic [7:0]    alloc_result_o,
  input logic          rx_int_set_o,
  input logic          rx_int_clr_o
);
  localparam logic [CW-1:0] ALL_C = CW'(NUM_PAGES);

  assert_grant_not_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_grant_o |-> pages_used_o < ALL_C);

  assert_grant_counts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_grant_o |=> pages_used_o == $past(pages_used_o) + CW'(1));

  assert_tx_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_enable_i && !cmd_valid_i));

  assert_head_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_head_o == 8'h80 || rx_head_o < 8'(NUM_PAGES)) &&
    (done_head_o == 8'h80 || done_head_o < 8'(NUM_PAGES)));

  assert_reset_cmd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd2) |=>
      (pages_used_o == '0 && rx_head_o == 8'h80 && done_head_o == 8'h80 && alloc_result_o == 8'h00));

  assert_alloc_fail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd1 && pages_used_o == ALL_C) |=> alloc_result_o == 8'h80);

  assert_rx_int_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_int_set_o && rx_int_clr_o));
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_op_i       (cmd_op_i),
  .tx_enable_i    (tx_enable_i),
  .rx_grant_o     (rx_grant_o),
  .tx_valid_o     (tx_valid_o),
  .pages_used_o   (pages_used_o),
  .rx_head_o      (rx_head_o),
  .done_head_o    (done_head_o),
  .alloc_result_o (alloc_result_o),
  .rx_int_set_o   (rx_int_set_o),
  .rx_int_clr_o   (rx_int_clr_o)
);

// File: tb/pkt_page_alloc_bench.sv
module pkt_page_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       cmd_v = 0, auto_rel = 0, txen = 0, deq = 0, rxreq = 0, dpop = 0;
  logic [2:0] op = 0;
  logic [1:0] pkt = 0;

  logic       rx_grant, tx_valid, a_set, a_clr, r_set, r_clr;
  logic [1:0] rx_page, tx_page;
  logic [7:0] a_res, rx_head, d_head;
  logic [2:0] used;

  pkt_page_alloc #(.NUM_PAGES(NP)) u_pkt_page_alloc (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_v), .cmd_op_i(op), .pkt_num_i(pkt),
    .auto_release_i(auto_rel), .tx_enable_i(txen), .tx_deq_i(deq),
    .rx_alloc_req_i(rxreq), .done_pop_i(dpop),
    .rx_grant_o(rx_grant), .rx_page_o(rx_page), .tx_valid_o(tx_valid), .tx_page_o(tx_page),
    .alloc_result_o(a_res), .pages_used_o(used), .rx_head_o(rx_head), .done_head_o(d_head),
    .alloc_done_set_o(a_set), .alloc_done_clr_o(a_clr),
    .rx_int_set_o(r_set), .rx_int_clr_o(r_clr)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  int bm = 0, res = 0;
  int rxq[$], txq[$], dq[$];

  function automatic int lowest_free(int m);
    for (int i = 0; i < NP; i++) if (((m >> i) & 1) == 0) return i;
    return -1;
  endfunction

  function automatic int popc(int m);
    int n = 0;
    for (int i = 0; i < NP; i++) n += (m >> i) & 1;
    return n;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: compare at the current low phase, then advance the model at the edge
  task automatic cyc(string tag);
    int c, rxn, txn, dn, rel, bmr, lf, head;
    bit txv, fire, tryit, aok, grant;
    #1;
    c = cmd_v ? int'(op) : 0;
    rxn = rxq.size(); txn = txq.size(); dn = dq.size();
    txv = txen && txn > 0 && !cmd_v;
    fire = deq && txv;
    rel = -1;
    if (c == 4 && rxn > 0) rel = rxq[0];
    else if (c == 5) rel = int'(pkt);
    else if (fire && auto_rel) rel = txq[0];
    bmr = (rel >= 0) ? (bm & ~(1 << rel)) : bm;
    lf = lowest_free(bmr);
    tryit = (c == 1) || (rel >= 0 && res == 128);
    aok = tryit && lf >= 0;
    grant = rxreq && !cmd_v && !fire && lf >= 0;

    chk(tag, "alloc_result", int'(a_res), res);
    chk(tag, "pages_used", int'(used), popc(bm));
    chk(tag, "rx_head", int'(rx_head), rxn > 0 ? rxq[0] : 128);
    chk(tag, "done_head", int'(d_head), dn > 0 ? dq[0] : 128);
    chk(tag, "tx_valid", int'(tx_valid), int'(txv));
    if (txv) chk(tag, "tx_page", int'(tx_page), txq[0]);
    chk(tag, "rx_grant", int'(rx_grant), int'(grant));
    if (grant) chk(tag, "rx_page", int'(rx_page), lf);
    chk(tag, "alloc_set", int'(a_set), int'(aok));
    chk(tag, "alloc_clr", int'(a_clr), int'(c == 1));
    chk(tag, "rx_int_set", int'(r_set), int'(grant || ((c == 3 || c == 4) && rxn > 1)));
    chk(tag, "rx_int_clr", int'(r_clr), int'((c == 3 || c == 4) && rxn <= 1));

    @(posedge clk);
    if (c == 2) begin
      bm = 0; res = 0;
      rxq.delete(); txq.delete(); dq.delete();
    end else begin
      bm = bmr;
      if (aok) begin bm |= 1 << lf; res = lf; end
      else if (c == 1) res = 128;
      if (grant) begin bm |= 1 << lf; if (rxn < NP) rxq.push_back(lf); end
      if ((c == 3 || c == 4) && rxn > 0) void'(rxq.pop_front());
      if (c == 6 && txn < NP) txq.push_back(int'(pkt));
      if (c == 7) begin
        txq.delete(); dq.delete();
      end else begin
        head = fire ? txq[0] : 0;
        if (fire) void'(txq.pop_front());
        if (dpop && dn > 0) void'(dq.pop_front());
        if (fire && !auto_rel && dn < NP) dq.push_back(head);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    cmd_v = 0; deq = 0; rxreq = 0; dpop = 0;
  endtask

  task automatic cmd(int o, int p, string tag);
    idle_in(); cmd_v = 1; op = 3'(o); pkt = 2'(p);
    cyc(tag);
    cmd_v = 0;
  endtask

  task automatic rx_req(string tag);
    idle_in(); rxreq = 1; cyc(tag); rxreq = 0;
  endtask

  task automatic tx_strobe(string tag);
    idle_in(); deq = 1; cyc(tag); deq = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 R9: reset state, heads empty, nothing used, result 0
    cyc("R5");
    cyc("R9");
    // R11: four grants take pages 0..3, fifth refused
    for (int i = 0; i < 5; i++) rx_req("R11");
    // R1: allocate for transmit with all pages used fails
    cmd(1, 0, "R1");
    cyc("R1");
    // R2: invalid strobe and opcode 0 leave state alone
    idle_in(); op = 3'd2; cyc("R2");
    cmd(0, 0, "R2");
    cyc("R2");
    // R4: releasing page 2 retries pending allocation
    cmd(5, 2, "R4");
    cyc("R4");
    // R6: pops from receive queue, with and without release
    cmd(3, 0, "R6");
    cmd(4, 0, "R6");
    cmd(4, 0, "R6");
    cmd(3, 0, "R6");
    cmd(3, 0, "R6");
    cyc("R6");
    // R12: full reset
    cmd(2, 0, "R12");
    cyc("R12");
    // R3: successful allocations, lowest free first
    cmd(1, 0, "R3");
    cmd(1, 0, "R3");
    cyc("R3");
    // R8: five enqueues, last ignored
    for (int i = 0; i < 5; i++) cmd(6, i % 4, "R8");
    // R10: strobe with transmit disabled does nothing
    txen = 0; tx_strobe("R10");
    txen = 1; auto_rel = 0;
    tx_strobe("R10");
    // R10: command in same cycle blocks the dequeue
    cmd_v = 1; op = 3'd0; deq = 1; cyc("R10"); idle_in();
    // R7: no auto-release fills completion queue
    tx_strobe("R7");
    tx_strobe("R7");
    // R13: acknowledge completion entries, extra pop on empty
    idle_in(); dpop = 1; deq = 1; cyc("R13");
    for (int i = 0; i < 4; i++) begin idle_in(); dpop = 1; cyc("R13"); end
    // R12: opcode 7 clears transmit side only
    cmd(6, 1, "R12");
    txen = 0;
    tx_strobe("R12");
    cmd(7, 0, "R12");
    cyc("R12");
    cmd(2, 0, "R12");
    // R4 R7: pending allocation satisfied by auto-release on transmit
    for (int i = 0; i < 4; i++) rx_req("R7");
    cmd(6, 1, "R7");
    cmd(1, 0, "R4");
    txen = 1; auto_rel = 1;
    tx_strobe("R4");
    cyc("R4");
    cmd(2, 0, "R12");
    // R10: mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      idle_in();
      cmd_v = ($urandom % 4) == 0;
      op = 3'($urandom);
      if (op == 3'd2 && ($urandom % 4) != 0) op = 3'd6;
      pkt = 2'($urandom);
      auto_rel = ($urandom % 3) == 0;
      txen = ($urandom % 4) != 0;
      deq = ($urandom % 2) == 0;
      rxreq = ($urandom % 2) == 0;
      dpop = ($urandom % 3) == 0;
      cyc("R10");
    end
    idle_in();
    cyc("R10");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule